// File: doc/BRIEF.md
# Character-Driven JTAG Pin Controller

This block turns a stream of single-byte commands, for instance bytes coming out of a UART receiver, into levels on the three JTAG driver pins. Each accepted command byte is decoded on its own. A digit character sets the clock, mode-select and data-in pins together. A read character makes the block return the level of the data-out pin as an ASCII digit. A quit character ends the session with a one-cycle status pulse. Command bytes enter on a valid/ready channel, and the readback byte leaves on a second valid/ready channel.

Control sits in a two-state machine. In state LISTEN the block accepts command bytes. The transition READ_SEEN, taken when a read character is accepted, moves it to state ANSWER. In ANSWER the reply byte is offered downstream and the command input is stalled. The transition REPLY_TAKEN, taken when the reply is accepted, returns it to LISTEN. Because the input stalls while a reply waits, every reply stays in order with the commands around it.

Top module: `bb_jtag_driver`

## Requirements
- R1: After reset, tck, tms and tdi are low, out_valid and disconnect are low, and in_ready is high.
- R2: When a byte from 0x30 to 0x37 is accepted, take v = byte − 0x30. On the next cycle tck equals bit 2 of v, tms equals bit 1 and tdi equals bit 0.
- R3: The pins keep their levels until the next digit byte is accepted. Any accepted byte that is not a digit, not 0x52 and not 0x51 leaves the pins unchanged, produces no reply and no pulse, and is still accepted (in_ready high).
- R4: When 0x52 ('R') is accepted, out_valid rises on the next cycle and out_data is 0x31 if tdo was high at the accepting edge, or 0x30 if it was low. A later change of tdo does not alter the pending byte.
- R5: While out_valid is high and out_ready is low, out_valid and out_data hold. The cycle after a handshake, out_valid is low.
- R6: in_ready is low whenever a reply is pending, so no command byte is taken until the reply has been accepted.
- R7: When 0x51 ('Q') is accepted, disconnect is high for exactly the next cycle, and no reply is produced.
- R8: Accepting 0x52 or 0x51 leaves tck, tms and tdi unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Command byte |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Block can take a command byte |
| tdo | input | 1 | JTAG data-out level from the target |
| tck | output | 1 | JTAG clock pin level |
| tms | output | 1 | JTAG mode-select pin level |
| tdi | output | 1 | JTAG data-in pin level |
| out_data | output | 8 | Readback byte, ASCII '0' or '1' |
| out_valid | output | 1 | Readback byte present |
| out_ready | input | 1 | Downstream takes the readback byte |
| disconnect | output | 1 | One-cycle end-of-session pulse |

## Verification
A machine stuck in ANSWER holds in_ready low. The next command then stalls, and the pins fail to follow it one cycle after it is presented. A machine that leaves ANSWER early drops out_valid before the handshake, so the reply vanishes on the very next cycle. A decoder that misclassifies a byte shows up one cycle after that byte is accepted, as a wrong pin level, a spurious reply or a spurious pulse. The sweep sends every one of the 256 byte values, each after a known pin setting, so each misclassification appears at the ports within a single command.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BYTE_W = 8;
    localparam int PIN_W  = 3;

    localparam logic [BYTE_W-1:0] CH_DIGIT0 = 8'h30;
    localparam logic [BYTE_W-1:0] CH_READ   = 8'h52;
    localparam logic [BYTE_W-1:0] CH_QUIT   = 8'h51;
    localparam int                DIGIT_CNT = 1 << PIN_W;

    typedef enum logic [1:0] {
        K_NONE,
        K_PINS,
        K_READ,
        K_QUIT
    } cmd_kind_t;

    typedef enum logic {
        ST_LISTEN,
        ST_ANSWER
    } fsm_state_t;

    typedef struct packed {
        logic clk_lvl;
        logic mode_lvl;
        logic din_lvl;
    } pin_set_t;

endpackage

// File: rtl/bb_cmd_decode.sv
module bb_cmd_decode
    import bb_pkg::*;
(
    input  logic [BYTE_W-1:0] in_byte,
    output cmd_kind_t         kind,
    output pin_set_t          pin_val
);

    logic [BYTE_W-1:0] offset;
    logic              is_digit;

    always_comb begin
        offset   = in_byte - CH_DIGIT0;
        is_digit = (in_byte >= CH_DIGIT0) && (offset < BYTE_W'(DIGIT_CNT));
    end

    always_comb begin
        pin_val = pin_set_t'(offset[PIN_W-1:0]);
        if (is_digit) begin
            kind = K_PINS;
        end else if (in_byte == CH_READ) begin
            kind = K_READ;
        end else if (in_byte == CH_QUIT) begin
            kind = K_QUIT;
        end else begin
            kind = K_NONE;
        end
    end

endmodule

// File: rtl/bb_pin_reg.sv
module bb_pin_reg
    import bb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  pin_set_t pin_val,
    output logic     tck,
    output logic     tms,
    output logic     tdi
);

    pin_set_t pins_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else if (load) begin
            pins_q <= pin_val;
        end
    end

    always_comb begin
        tck = pins_q.clk_lvl;
        tms = pins_q.mode_lvl;
        tdi = pins_q.din_lvl;
    end

endmodule

// File: rtl/bb_reply_buf.sv
module bb_reply_buf
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tdo_bit,
    output logic [BYTE_W-1:0] reply
);

    logic [BYTE_W-1:0] reply_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_q <= CH_DIGIT0;
        end else if (load) begin
            reply_q <= CH_DIGIT0 + BYTE_W'(tdo_bit);
        end
    end

    assign reply = reply_q;

endmodule

// File: rtl/bb_jtag_driver.sv
module bb_jtag_driver
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              disconnect
);

    fsm_state_t state_q;
    fsm_state_t state_d;
    cmd_kind_t  kind;
    pin_set_t   pin_val;
    logic       accept;
    logic       pin_load;
    logic       reply_load;
    logic       quit_seen;
    logic       disc_q;

    bb_cmd_decode u_dec (
        .in_byte (in_data),
        .kind    (kind),
        .pin_val (pin_val)
    );

    always_comb begin
        accept     = in_valid && in_ready;
        pin_load   = accept && (kind == K_PINS);
        reply_load = accept && (kind == K_READ);
        quit_seen  = accept && (kind == K_QUIT);
    end

    bb_pin_reg u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pin_load),
        .pin_val (pin_val),
        .tck     (tck),
        .tms     (tms),
        .tdi     (tdi)
    );

    bb_reply_buf u_reply (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reply_load),
        .tdo_bit (tdo),
        .reply   (out_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LISTEN;
            disc_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            disc_q  <= quit_seen;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LISTEN: begin
                if (reply_load) begin
                    state_d = ST_ANSWER;
                end
            end
            ST_ANSWER: begin
                if (out_ready) begin
                    state_d = ST_LISTEN;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_LISTEN: in_ready  = 1'b1;
            ST_ANSWER: out_valid = 1'b1;
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        disconnect = disc_q;
    end

endmodule

// File: rtl/bb_jtag_driver_chk.sv
module bb_jtag_driver_chk
    import bb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic              tdo,
    input logic              tck,
    input logic              tms,
    input logic              tdi,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              disconnect
);

    logic took;
    logic took_digit;
    assign took       = in_valid && in_ready;
    assign took_digit = took && (in_data >= 8'h30) && (in_data <= 8'h37);

    p_digit_sets_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        took_digit |=> ({tck, tms, tdi} == $past(in_data[2:0])));

    p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !took_digit |=> $stable({tck, tms, tdi}));

    p_reply_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (took && in_data == 8'h52) |=> (out_valid && out_data == (8'h30 + {7'd0, $past(tdo)})));

    p_reply_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_reply_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_quit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (took && in_data == 8'h51) |=> (disconnect && !out_valid));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |=> !disconnect);

endmodule

bind bb_jtag_driver bb_jtag_driver_chk u_chk (.*);

// File: tb/tb_bb_jtag_driver.sv
module tb_bb_jtag_driver;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       tdo = 1'b0;
    logic       tck, tms, tdi;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       disconnect;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_jtag_driver dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .disconnect(disconnect)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_reply();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({tck, tms, tdi} == 3'b000, "R1", "pins", {tck, tms, tdi}, 0);
        check(!out_valid, "R1", "out_valid", out_valid, 0);
        check(!disconnect, "R1", "disconnect", disconnect, 0);
        check(in_ready, "R1", "in_ready", in_ready, 1);

        // Exhaustive sweep: known pin setting, then every byte value
        for (int b = 0; b < 256; b++) begin
            logic [2:0] pre;
            logic [2:0] exp_pins;
            bit is_dig;
            pre    = 3'(b % 8) ^ 3'b101;
            tdo    = 1'b0;
            send(8'h30 + {5'd0, pre});
            check({tck, tms, tdi} == pre, "R2", "setup pins", {tck, tms, tdi}, pre);
            check(in_ready, "R3", "in_ready before byte", in_ready, 1);
            send(8'(b));
            is_dig   = (b >= 48) && (b <= 55);
            exp_pins = is_dig ? 3'(b - 48) : pre;
            if (is_dig)
                check({tck, tms, tdi} == exp_pins, "R2", "digit pins", {tck, tms, tdi}, exp_pins);
            else if (b == 8'h52 || b == 8'h51)
                check({tck, tms, tdi} == exp_pins, "R8", "pins after R/Q", {tck, tms, tdi}, exp_pins);
            else
                check({tck, tms, tdi} == exp_pins, "R3", "ignored byte pins", {tck, tms, tdi}, exp_pins);
            check(disconnect == (b == 8'h51), "R7", "pulse", disconnect, (b == 8'h51));
            check(out_valid == (b == 8'h52), "R4", "reply presence", out_valid, (b == 8'h52));
            if (b == 8'h52) begin
                check(out_data == 8'h30, "R4", "reply tdo=0", out_data, 8'h30);
                pop_reply();
                check(!out_valid, "R5", "cleared after take", out_valid, 0);
            end else begin
                @(negedge clk);
                check(!disconnect, "R7", "pulse one cycle", disconnect, 0);
            end
        end

        // Reply with tdo high, backpressure, stall of the next command
        send(8'h32);
        tdo = 1'b1;
        send(8'h52);
        tdo = 1'b0;
        check(out_valid && out_data == 8'h31, "R4", "reply tdo=1", out_data, 8'h31);
        in_data  = 8'h37;
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!in_ready, "R6", "stalled input", in_ready, 0);
            check(out_valid && out_data == 8'h31, "R5", "reply held", out_data, 8'h31);
            check({tck, tms, tdi} == 3'b010, "R6", "pins not yet changed", {tck, tms, tdi}, 2);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid, "R5", "reply gone", out_valid, 0);
        check({tck, tms, tdi} == 3'b010, "R6", "pins before resume", {tck, tms, tdi}, 2);
        check(in_ready, "R6", "input resumes", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check({tck, tms, tdi} == 3'b111, "R6", "stalled byte applied", {tck, tms, tdi}, 7);

        // Quit: no reply, single pulse
        send(8'h51);
        check(disconnect && !out_valid, "R7", "quit pulse", disconnect, 1);
        @(negedge clk);
        check(!disconnect && !out_valid, "R7", "quit ends", disconnect, 0);
        check({tck, tms, tdi} == 3'b111, "R8", "pins after quit", {tck, tms, tdi}, 7);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule